// File: doc/BRIEF.md
# Timebase-Locked Transition Pulse Generator

This block drives one output pin with a train of level transitions, such as the step line of a stepper driver. A down-counting timebase, reloaded from a committed period value, splits time into a fixed grid of ticks. On each tick the block looks at its committed transition budget. If the budget is non-zero, the output toggles and the budget drops by one. A full step pulse therefore costs two transitions. Once the budget is used up, the output keeps its last level and a done flag goes high.

Software loads the period and the transition budget through single-cycle write strobes. Both values pass through shadow registers and take effect only on a grid tick. A new segment can therefore follow the running one with no reset and no glitch. The enable input works as a synchronous hold: while it is low the timebase, the output and the live budget are cleared. The shadow registers still accept writes while enable is low. Several instances that are loaded and then enabled on the same clock share the same tick grid, so they start together and later update together.

Top module: `tbgen_top`

## Requirements
- R1: On the first enabled clock after the block was held, the timebase takes the committed period P and starts a run. The first tick falls P clocks later, and each following tick falls P clocks after the one before. A period value of 0 means 65536 clocks.
- R2: On a tick with a non-zero committed budget, the output inverts and the budget decrements. On a tick with a zero budget, the output holds its level.
- R3: After enable rises, the output stays low for the whole first timebase period. The first transition can come no earlier than the first tick.
- R4: A period write made while a period is running does not change that period's length. The new value sets the length of the periods that start at the next tick.
- R5: A budget write is committed at the next tick, and that same tick already consumes it. A budget write made in the very clock of a tick is committed, and consumed, at that tick.
- R6: A period write and a budget write made within the same period are both committed at the same tick.
- R7: With enable low, the next clock clears the output, the live budget, the timebase and the done flag. Shadowed writes made while enable is low are kept and used after enable rises.
- R8: The done flag rises on the tick that consumes the last unit of the budget. A budget write made outside a tick clears the flag on the next clock.
- R9: The output changes level only on tick clocks while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all state including the shadows |
| enable | input | 1 | Run enable; low holds the block idle |
| period_wr | input | 1 | Strobe that writes period_data into the period shadow |
| period_data | input | PERIOD_W | Timebase period in clocks (0 means 2^PERIOD_W) |
| count_wr | input | 1 | Strobe that writes count_data into the budget shadow |
| count_data | input | COUNT_W | Number of output transitions to produce |
| pulse_out | output | 1 | Transition output |
| done | output | 1 | High once the committed budget has been used up |

## Verification
If the timebase counter or the committed period goes wrong, the output edges land off the expected grid, and the per-clock comparison against the reference model catches this on the first misplaced tick. That is at most one period after the fault. If the shadow or the live budget goes wrong, the train carries too many or too few transitions, or done rises on the wrong tick. Either shows up at the tick where the budget should have run out, or at the first tick after a missed commit. A fault in the hold path shows up on the clock after enable falls.

// File: rtl/tbgen_pkg.sv
package tbgen_pkg;

   // Run state of the timebase.
   typedef enum logic [0:0] {
      TB_HALT = 1'b0,
      TB_RUN  = 1'b1
   } tb_state_e;

   localparam int unsigned TBGEN_MIN_PERIOD_W = 2;
   localparam int unsigned TBGEN_MAX_PERIOD_W = 32;
   localparam int unsigned TBGEN_MIN_COUNT_W  = 1;
   localparam int unsigned TBGEN_MAX_COUNT_W  = 32;

endpackage

// File: rtl/tbgen_timebase.sv
module tbgen_timebase
   import tbgen_pkg::*;
#(
   parameter int unsigned PERIOD_W     = 16,
   parameter bit          ZERO_AS_FULL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                period_wr,
   input  logic [PERIOD_W-1:0] period_data,
   output logic                tick,
   output logic                running
);

   localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

   tb_state_e           state_q;
   logic [PERIOD_W-1:0] cnt_q;
   logic [PERIOD_W-1:0] shadow_q;
   logic                pend_q;
   logic [PERIOD_W-1:0] cur_q;
   logic [PERIOD_W-1:0] eff_per;
   logic [PERIOD_W-1:0] load_val;
   logic                start;

   // A write in the commit clock is taken directly.
   assign eff_per = period_wr ? period_data : (pend_q ? shadow_q : cur_q);
   assign start   = enable && (state_q == TB_HALT);
   assign tick    = enable && (state_q == TB_RUN) && (cnt_q == ONE);
   assign running = (state_q == TB_RUN);

   generate
      if (ZERO_AS_FULL) begin : g_zero_full
         // A loaded 0 wraps through the full counter range.
         assign load_val = eff_per;
      end else begin : g_zero_one
         assign load_val = (eff_per == '0) ? ONE : eff_per;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= TB_HALT;
         cnt_q    <= '0;
         shadow_q <= '0;
         pend_q   <= 1'b0;
         cur_q    <= '0;
      end else if (!enable) begin
         state_q <= TB_HALT;
         cnt_q   <= '0;
         if (period_wr) begin
            shadow_q <= period_data;
            pend_q   <= 1'b1;
         end
      end else if (start || tick) begin
         state_q <= TB_RUN;
         cnt_q   <= load_val;
         cur_q   <= eff_per;
         pend_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_q - ONE;
         if (period_wr) begin
            shadow_q <= period_data;
            pend_q   <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/tbgen_budget.sv
module tbgen_budget #(
   parameter int unsigned COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               tick,
   input  logic               count_wr,
   input  logic [COUNT_W-1:0] count_data,
   output logic               toggle,
   output logic               done
);

   localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

   logic [COUNT_W-1:0] live_q;
   logic [COUNT_W-1:0] shadow_q;
   logic               pend_q;
   logic               done_q;
   logic [COUNT_W-1:0] eff_cnt;
   logic               nonzero;

   assign eff_cnt = count_wr ? count_data : (pend_q ? shadow_q : live_q);
   assign nonzero = (eff_cnt != '0);
   assign toggle  = tick && nonzero;
   assign done    = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q   <= '0;
         shadow_q <= '0;
         pend_q   <= 1'b0;
         done_q   <= 1'b0;
      end else if (!enable) begin
         live_q <= '0;
         done_q <= 1'b0;
         if (count_wr) begin
            shadow_q <= count_data;
            pend_q   <= 1'b1;
         end
      end else if (tick) begin
         live_q <= nonzero ? (eff_cnt - ONE) : '0;
         pend_q <= 1'b0;
         if (eff_cnt == ONE)
            done_q <= 1'b1;
         else if (count_wr)
            done_q <= 1'b0;
      end else if (count_wr) begin
         shadow_q <= count_data;
         pend_q   <= 1'b1;
         done_q   <= 1'b0;
      end
   end

endmodule

// File: rtl/tbgen_outreg.sv
module tbgen_outreg #(
   parameter bit IDLE_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic toggle,
   output logic pin
);

   logic pin_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !enable)
         pin_q <= IDLE_LEVEL;
      else if (toggle)
         pin_q <= ~pin_q;
   end

   assign pin = pin_q;

endmodule

// File: rtl/tbgen_top.sv
module tbgen_top
   import tbgen_pkg::*;
#(
   parameter int unsigned PERIOD_W     = 16,
   parameter int unsigned COUNT_W      = 32,
   parameter bit          ZERO_AS_FULL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable,
   input  logic                period_wr,
   input  logic [PERIOD_W-1:0] period_data,
   input  logic                count_wr,
   input  logic [COUNT_W-1:0]  count_data,
   output logic                pulse_out,
   output logic                done
);

   generate
      if (PERIOD_W < TBGEN_MIN_PERIOD_W || PERIOD_W > TBGEN_MAX_PERIOD_W) begin : g_bad_pw
         $error("tbgen_top: PERIOD_W out of range");
      end
      if (COUNT_W < TBGEN_MIN_COUNT_W || COUNT_W > TBGEN_MAX_COUNT_W) begin : g_bad_cw
         $error("tbgen_top: COUNT_W out of range");
      end
   endgenerate

   logic tick;
   logic running;
   logic toggle;

   tbgen_timebase #(
      .PERIOD_W    (PERIOD_W),
      .ZERO_AS_FULL(ZERO_AS_FULL)
   ) u_tb (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .period_wr  (period_wr),
      .period_data(period_data),
      .tick       (tick),
      .running    (running)
   );

   tbgen_budget #(
      .COUNT_W(COUNT_W)
   ) u_budget (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .tick      (tick),
      .count_wr  (count_wr),
      .count_data(count_data),
      .toggle    (toggle),
      .done      (done)
   );

   tbgen_outreg #(
      .IDLE_LEVEL(1'b0)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .enable(enable),
      .toggle(toggle),
      .pin   (pulse_out)
   );

endmodule

// File: rtl/tbgen_chk.sv
module tbgen_chk (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic count_wr,
   input logic pulse_out,
   input logic done,
   input logic tick,
   input logic running
);

   assert_hold_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!pulse_out && !done && !running));

   assert_edge_on_grid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && $past(enable) && (pulse_out != $past(pulse_out))) |-> $past(tick));

   assert_done_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(tick));

   assert_write_clears_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (count_wr && enable && !tick) |=> !done);

   assert_first_period_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> !pulse_out);

endmodule

bind tbgen_top tbgen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .enable   (enable),
   .count_wr (count_wr),
   .pulse_out(pulse_out),
   .done     (done),
   .tick     (tick),
   .running  (running)
);

// File: tb/sim_tbgen_top.sv
module sim_tbgen_top;

   localparam int CLK_PERIOD = 10;
   localparam int PW = 16;
   localparam int CW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          period_wr = 1'b0;
   logic [PW-1:0] period_data = '0;
   logic          count_wr = 1'b0;
   logic [CW-1:0] count_data = '0;
   logic          pulse_out;
   logic          done;

   int    checks = 0;
   int    errors = 0;
   bit    finished = 0;
   string tag = "R1";

   // Reference model state
   bit m_run, m_out, m_done, m_ppend, m_cpend;
   int m_left, m_psh, m_pcur, m_csh, m_act;

   always #(CLK_PERIOD/2) clk = ~clk;

   tbgen_top #(.PERIOD_W(PW), .COUNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .period_wr(period_wr), .period_data(period_data),
      .count_wr(count_wr), .count_data(count_data),
      .pulse_out(pulse_out), .done(done)
   );

   task automatic mstep(bit en, bit pw, int pd, bit cw, int cd);
      bit bnd;
      int ep, ec;
      if (!rst_n) begin
         m_run = 0; m_out = 0; m_done = 0; m_ppend = 0; m_cpend = 0;
         m_left = 0; m_psh = 0; m_pcur = 0; m_csh = 0; m_act = 0;
         return;
      end
      if (!en) begin
         m_run = 0; m_left = 0; m_out = 0; m_act = 0; m_done = 0;
         if (pw) begin m_psh = pd; m_ppend = 1; end
         if (cw) begin m_csh = cd; m_cpend = 1; end
         return;
      end
      bnd = m_run && (m_left == 1);
      if (!m_run || bnd) begin
         ep = pw ? pd : (m_ppend ? m_psh : m_pcur);
         m_pcur = ep; m_ppend = 0;
         m_left = (ep == 0) ? (1 << PW) : ep;
      end else begin
         m_left = m_left - 1;
         if (pw) begin m_psh = pd; m_ppend = 1; end
      end
      if (bnd) begin
         ec = cw ? cd : (m_cpend ? m_csh : m_act);
         m_cpend = 0;
         if (ec != 0) begin
            m_out = !m_out;
            m_act = ec - 1;
         end else begin
            m_act = 0;
         end
         if (ec == 1) m_done = 1;
         else if (cw) m_done = 0;
      end else if (cw) begin
         m_csh = cd; m_cpend = 1; m_done = 0;
      end
      m_run = 1;
   endtask

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // One clock: drive at negedge, model at posedge, compare at next negedge.
   task automatic cyc(bit en, bit pw = 0, int pd = 0, bit cw = 0, int cd = 0);
      enable = en; period_wr = pw; period_data = PW'(pd);
      count_wr = cw; count_data = CW'(cd);
      @(posedge clk);
      mstep(en, pw, pd, cw, cd);
      @(negedge clk);
      check(tag, "pulse_out", int'(pulse_out), int'(m_out));
      check(tag, "done", int'(done), int'(m_done));
   endtask

   task automatic idle(int n, bit en = 1);
      for (int i = 0; i < n; i++) cyc(en);
   endtask

   // Run until the next clock edge is a tick.
   task automatic to_tick();
      int guard = 0;
      while (!(m_run && m_left == 1) && guard < 70000) begin
         cyc(1);
         guard++;
      end
   endtask

   initial begin
      @(negedge clk);
      tag = "R7";
      rst_n = 0;
      idle(3, 0);
      rst_n = 1;
      check("R7", "reset pulse_out", int'(pulse_out), 0);
      check("R7", "reset done", int'(done), 0);

      // Load while held, then start: R1 R2 R3 R8
      cyc(0, 1, 4, 1, 5);
      tag = "R3";
      cyc(1);
      idle(3);
      check("R3", "low through first period", int'(pulse_out), 0);
      tag = "R2";
      idle(30);
      check("R8", "done after budget", int'(done), 1);
      check("R2", "level held after budget", int'(pulse_out), 1);

      // New segment mid-period: R4 R5 R6, done cleared R8
      tag = "R8";
      cyc(1, 0, 0, 1, 4);
      check("R8", "done cleared by write", int'(done), 0);
      tag = "R6";
      cyc(1, 1, 2);
      tag = "R4";
      idle(20);

      // Budget write in the same clock as a tick: R5
      tag = "R5";
      to_tick();
      cyc(1, 0, 0, 1, 3);
      check("R5", "same-clock write consumed", int'(pulse_out), 0);
      idle(10);

      // Period write while running keeps current period: R4
      tag = "R4";
      cyc(1, 0, 0, 1, 6);
      to_tick();
      cyc(1);
      cyc(1, 1, 5);
      idle(30);

      // Hold mid-train with shadowed writes: R7
      tag = "R7";
      cyc(1, 0, 0, 1, 9);
      idle(3);
      cyc(0);
      check("R7", "hold clears pulse_out", int'(pulse_out), 0);
      cyc(0, 1, 1, 1, 4);
      tag = "R9";
      idle(12);

      // Zero budget: output holds, no done: R2
      tag = "R2";
      cyc(1, 0, 0, 1, 0);
      idle(6);

      // Period 0 means full range: R1
      tag = "R1";
      cyc(0);
      cyc(0, 1, 0, 1, 1);
      cyc(1);
      idle(65534);
      check("R1", "no tick before 65536 clocks", int'(pulse_out), 0);
      idle(3);
      check("R1", "tick at 65536 clocks", int'(pulse_out), 1);

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog run did not end actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule